// File: doc/BRIEF.md
# Compare-Capture Timer-Counter

This block is a timer-counter with four compare/capture channels behind a 32-bit word register port. In timer mode the counter advances on prescaled pulses of a base tick enable. In counter mode it advances only when software writes the count task. The counter width is chosen from four sizes, and the counter wraps at that width.

Each channel holds a compare value. When an increment lands the counter on that value, the channel latches an event. Per-channel shortcut bits can zero the counter or halt the timer on that event. The enabled events are ORed into a single interrupt line. A capture task copies the live count into the channel's compare register, and a clear task zeroes the counter.

Registers are written with a single-cycle `we_i` strobe. `rdata_o` is a combinational view of the register addressed by `addr_i`.

Top module: `tc_top`

## Requirements
- R1: The width code at 0x90 bits[1:0] selects the counter width: 0 selects 16 bits, 1 selects 8, 2 selects 24 and 3 selects 32. The counter wraps modulo 2^width. A value written to compare register i (0xA0+4i) is stored masked to the width.
- R2: In timer mode (0x8C bit0 = 0) the counter advances by one per 2^p base tick pulses while running, where p is the prescaler at 0x94 bits[3:0]. The clear task also restarts this divider.
- R3: The start task (0x00) sets the running state only in timer mode. The stop task (0x04) clears it, and base ticks then have no effect on the counter.
- R4: In counter mode (0x8C bit0 = 1) the count task (0x08) increments the counter by one and base ticks are ignored.
- R5: After any increment, channel i's event (read at 0x40+4i, bit0) sets when the new count equals compare value i. The event holds until 0 is written to its address. Nonzero writes to that address do nothing. A set in the same cycle as a clear write leaves the event set.
- R6: Shortcut bit i (0x80) zeroes the counter when channel i's event fires.
- R7: Shortcut bit i+8 (0x80) stops the timer when channel i's event fires.
- R8: Writing 0x84 ORs bits 19:16 into the interrupt mask, and writing 0x88 removes them. Both addresses read back the mask at bits 19:16. irq_o is high when any channel has both its event set and mask bit 16+i set.
- R9: The capture task for channel i (0x10+4i) copies the counter value from before that cycle's increment into compare register i.
- R10: The clear task (0x0C) zeroes the counter whether or not the timer is running, and it wins over an increment in the same cycle.
- R11: A task fires only when the value written to its address is exactly 1. Any other value is ignored.
- R12: Reset zeroes the counter, running state, events, compare values, shortcuts, mask, mode, width code and prescaler. Reads of unmapped offsets such as 0xFC return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_tick_i | input | 1 | Base tick enable feeding the prescaler |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two pairs of operations can land in the same cycle. In the first, a base tick moves the counter onto a compare value while software writes 0 to that channel's event. The bench raises base_tick_i during the event-clear write and then expects the event to read 1. In the second, a base tick coincides with the clear task or with a capture task. The bench checks the count through a later capture: it expects 0 after the clear, and the pre-increment value in the captured register.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [7:0] A_START  = 8'h00;
  localparam logic [7:0] A_STOP   = 8'h04;
  localparam logic [7:0] A_COUNT  = 8'h08;
  localparam logic [7:0] A_CLEAR  = 8'h0C;
  localparam logic [7:0] A_CAP    = 8'h10;
  localparam logic [7:0] A_EVENT  = 8'h40;
  localparam logic [7:0] A_SHORTS = 8'h80;
  localparam logic [7:0] A_IEN_S  = 8'h84;
  localparam logic [7:0] A_IEN_C  = 8'h88;
  localparam logic [7:0] A_MODE   = 8'h8C;
  localparam logic [7:0] A_WIDTH  = 8'h90;
  localparam logic [7:0] A_PSC    = 8'h94;
  localparam logic [7:0] A_CC     = 8'hA0;

  typedef enum logic {MODE_TIMER = 1'b0, MODE_COUNTER = 1'b1} tc_mode_e;

  function automatic logic [31:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    width_mask = 32'h0000_FFFF;
      2'd1:    width_mask = 32'h0000_00FF;
      2'd2:    width_mask = 32'h00FF_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PSC_W = 4,
  localparam int DIV_W = (2 ** PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             base_tick_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, mask;

  assign mask   = (DIV_W'(1) << psc_i) - DIV_W'(1);
  assign tick_o = run_i && base_tick_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   div_q <= '0;
    else if (clr_i)                div_q <= '0;
    else if (run_i && base_tick_i) div_q <= div_q + DIV_W'(1);
  end

  assert_tick_needs_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (run_i && base_tick_i));
endmodule

// File: rtl/tc_channel.sv
module tc_channel #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wmask_i,
  input  logic          cc_we_i,
  input  logic [CW-1:0] cc_wdata_i,
  input  logic          cap_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] nxt_i,
  input  logic          inc_i,
  input  logic          ev_clr_i,
  output logic          match_o,
  output logic          ev_o,
  output logic [CW-1:0] cc_o
);
  logic [CW-1:0] cc_q;
  logic          ev_q;

  assign match_o = inc_i && (nxt_i == cc_q);
  assign ev_o    = ev_q;
  assign cc_o    = cc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q <= '0;
      ev_q <= 1'b0;
    end else begin
      if (cap_i)        cc_q <= cnt_i;
      else if (cc_we_i) cc_q <= cc_wdata_i & wmask_i;
      if (match_o)       ev_q <= 1'b1;
      else if (ev_clr_i) ev_q <= 1'b0;
    end
  end

  assert_ev_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_q && !ev_clr_i) |=> ev_q);
  assert_ev_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> ev_q);
  assert_cc_masked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_we_i && !cap_i) |=> ((cc_q & ~$past(wmask_i)) == '0));
  assert_cap_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (cc_q == $past(cnt_i)));
endmodule

// File: rtl/tc_top.sv
module tc_top
  import tc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PSC_W = 4,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int IEN_LSB = 16;
  localparam int STOP_LSB = 8;

  logic [DW-1:0]    cnt_q, nxt, wmask;
  logic             run_q;
  tc_mode_e         mode_q;
  logic [1:0]       width_q;
  logic [PSC_W-1:0] psc_q;
  logic [NCH-1:0]   sc_clr_q, sc_stop_q, ien_q;
  logic [NCH-1:0]   hit, ev, cap_t, cc_we, ev_clr;
  logic [DW-1:0]    cc [NCH];
  logic             wr_one, start_t, stop_t, count_t, clear_t, tick, inc;

  assign wr_one  = we_i && (wdata_i == DW'(1));
  assign start_t = wr_one && (addr_i == A_START) && (mode_q == MODE_TIMER);
  assign stop_t  = wr_one && (addr_i == A_STOP);
  assign count_t = wr_one && (addr_i == A_COUNT) && (mode_q == MODE_COUNTER);
  assign clear_t = wr_one && (addr_i == A_CLEAR);
  assign wmask   = width_mask(width_q);
  assign nxt     = (cnt_q + DW'(1)) & wmask;
  assign inc     = tick || count_t;
  assign irq_o   = |(ev & ien_q);

  tc_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i, .rst_ni,
    .run_i(run_q && (mode_q == MODE_TIMER)),
    .base_tick_i, .clr_i(clear_t), .psc_i(psc_q), .tick_o(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cap_t[i]  = wr_one && (addr_i == AW'(A_CAP + 4 * i));
    assign cc_we[i]  = we_i && (addr_i == AW'(A_CC + 4 * i));
    assign ev_clr[i] = we_i && (wdata_i == '0) && (addr_i == AW'(A_EVENT + 4 * i));
    tc_channel #(.CW(DW)) i_ch (
      .clk_i, .rst_ni, .wmask_i(wmask),
      .cc_we_i(cc_we[i]), .cc_wdata_i(wdata_i), .cap_i(cap_t[i]),
      .cnt_i(cnt_q), .nxt_i(nxt), .inc_i(inc), .ev_clr_i(ev_clr[i]),
      .match_o(hit[i]), .ev_o(ev[i]), .cc_o(cc[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; run_q <= 1'b0; mode_q <= MODE_TIMER;
      width_q <= '0; psc_q <= '0;
      sc_clr_q <= '0; sc_stop_q <= '0; ien_q <= '0;
    end else begin
      if (clear_t)                  cnt_q <= '0;
      else if (inc && |(hit & sc_clr_q)) cnt_q <= '0;
      else if (inc)                 cnt_q <= nxt;

      if (stop_t)                          run_q <= 1'b0;
      else if (inc && |(hit & sc_stop_q))  run_q <= 1'b0;
      else if (start_t)                    run_q <= 1'b1;

      if (we_i) begin
        case (addr_i)
          A_SHORTS: begin
            sc_clr_q  <= wdata_i[NCH-1:0];
            sc_stop_q <= wdata_i[STOP_LSB +: NCH];
          end
          A_IEN_S: ien_q  <= ien_q | wdata_i[IEN_LSB +: NCH];
          A_IEN_C: ien_q  <= ien_q & ~wdata_i[IEN_LSB +: NCH];
          A_MODE:  mode_q <= tc_mode_e'(wdata_i[0]);
          A_WIDTH: width_q <= wdata_i[1:0];
          A_PSC:   psc_q  <= wdata_i[PSC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SHORTS: begin
        rdata_o[NCH-1:0]          = sc_clr_q;
        rdata_o[STOP_LSB +: NCH]  = sc_stop_q;
      end
      A_IEN_S, A_IEN_C: rdata_o[IEN_LSB +: NCH] = ien_q;
      A_MODE:  rdata_o[0]   = mode_q;
      A_WIDTH: rdata_o[1:0] = width_q;
      A_PSC:   rdata_o[PSC_W-1:0] = psc_q;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(A_EVENT + 4 * i)) rdata_o = {{(DW-1){1'b0}}, ev[i]};
      if (addr_i == AW'(A_CC + 4 * i))    rdata_o = cc[i];
    end
  end

  assert_clear_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_t |=> (cnt_q == '0));
  assert_short_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && |(hit & sc_clr_q)) |=> (cnt_q == '0));
  assert_short_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && |(hit & sc_stop_q)) |=> !run_q);
  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && (mode_q == MODE_TIMER) && !clear_t) |=> $stable(cnt_q));
  assert_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc |=> ((cnt_q & ~$past(wmask)) == '0));
endmodule

// File: tb/test_tc_top.sv
module test_tc_top;
  import tc_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  always #4 clk_i = ~clk_i;

  tc_top i_tc_top (.*);

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_req = 0;
  bit    done = 0;

  // monitor: compares in the low clock phase
  always @(negedge clk_i) begin
    #2;
    if (chk_req && exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 0);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d; base_tick_i = tk;
    @(posedge clk_i); #1;
    we_i = 1'b0; base_tick_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); base_tick_i = 1'b1;
      @(posedge clk_i); #1; base_tick_i = 1'b0;
    end
  endtask

  task automatic count(input int n);
    for (int k = 0; k < n; k++) wr(A_COUNT, 32'd1);
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    chk_req = 1;
    @(posedge clk_i); #1; chk_req = 0;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t it;
    @(negedge clk_i);
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    chk_req = 1;
    @(posedge clk_i); #1; chk_req = 0;
  endtask

  // read the counter through capture channel 3
  task automatic chk_cnt(input logic [31:0] e, input string tag);
    wr(8'h1C, 32'd1);
    chk_rd(8'hAC, e, tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R12 reset state
    chk_rd(8'hA0, 32'h0, "R12 cc0 reset");
    chk_rd(A_MODE, 32'h0, "R12 mode reset");
    chk_rd(A_WIDTH, 32'h0, "R12 width reset");
    chk_rd(A_PSC, 32'h0, "R12 prescaler reset");
    chk_rd(A_IEN_S, 32'h0, "R12 mask reset");
    chk_rd(A_SHORTS, 32'h0, "R12 shorts reset");
    chk_rd(8'h40, 32'h0, "R12 event0 reset");
    chk_irq(1'b0, "R12 irq reset");
    chk_rd(8'hFC, 32'h0, "R12 unmapped read");

    // R2 R3 timer, prescaler 0
    wr(A_START, 32'd1);
    tick(5);
    chk_cnt(32'd5, "R2 five ticks");
    wr(A_STOP, 32'd1);
    tick(3);
    chk_cnt(32'd5, "R3 stopped holds");

    // R2 prescaler 2
    wr(A_PSC, 32'd2);
    wr(A_CLEAR, 32'd1);
    wr(A_START, 32'd1);
    tick(8);
    chk_cnt(32'd2, "R2 psc2 eight pulses");
    tick(3);
    chk_cnt(32'd2, "R2 psc2 partial");
    tick(1);
    chk_cnt(32'd3, "R2 psc2 twelfth pulse");

    // R10 clear with same-cycle tick
    wr(A_PSC, 32'd0);
    tick(2);
    chk_cnt(32'd5, "R2 psc0 again");
    wr(A_CLEAR, 32'd1, 1'b1);
    chk_cnt(32'd0, "R10 clear beats tick");
    wr(A_STOP, 32'd1);

    // R4 counter mode, R11 value filter
    wr(A_MODE, 32'd1);
    wr(A_START, 32'd1);
    count(3);
    tick(4);
    chk_cnt(32'd3, "R4 counts not ticks");
    wr(A_MODE, 32'd0);
    tick(2);
    chk_cnt(32'd3, "R3 start ignored in counter mode");
    wr(A_MODE, 32'd1);
    wr(A_COUNT, 32'd2);
    chk_cnt(32'd3, "R11 count value 2 ignored");
    wr(A_CLEAR, 32'd3);
    chk_cnt(32'd3, "R11 clear value 3 ignored");

    // R1 width masking and wrap
    wr(A_WIDTH, 32'd1);
    wr(8'hA0, 32'h1FF);
    chk_rd(8'hA0, 32'hFF, "R1 8-bit cc mask");
    wr(A_WIDTH, 32'd2);
    wr(8'hA0, 32'hFFFF_FFFF);
    chk_rd(8'hA0, 32'h00FF_FFFF, "R1 24-bit cc mask");
    wr(A_WIDTH, 32'd3);
    wr(8'hA0, 32'hFFFF_FFFF);
    chk_rd(8'hA0, 32'hFFFF_FFFF, "R1 32-bit cc mask");
    wr(A_WIDTH, 32'd0);
    wr(8'hA0, 32'h0001_2345);
    chk_rd(8'hA0, 32'h2345, "R1 16-bit cc mask");
    wr(A_WIDTH, 32'd1);
    wr(A_CLEAR, 32'd1);
    count(257);
    chk_cnt(32'd1, "R1 8-bit wrap");

    // R5 R8 compare event and interrupt
    wr(A_WIDTH, 32'd0);
    wr(A_CLEAR, 32'd1);
    wr(8'h44, 32'd0);
    chk_rd(8'h44, 32'd0, "R5 event1 cleared");
    wr(8'hA4, 32'd3);
    count(2);
    chk_rd(8'h44, 32'd0, "R5 no event before match");
    count(1);
    chk_rd(8'h44, 32'd1, "R5 event on match");
    chk_irq(1'b0, "R8 irq masked");
    wr(8'h44, 32'd5);
    chk_rd(8'h44, 32'd1, "R5 nonzero write ignored");
    wr(A_IEN_S, 32'h0002_0000);
    chk_irq(1'b1, "R8 irq enabled");
    chk_rd(A_IEN_S, 32'h0002_0000, "R8 set readback");
    chk_rd(A_IEN_C, 32'h0002_0000, "R8 clr readback");
    wr(A_IEN_S, 32'h0001_0000);
    chk_rd(A_IEN_S, 32'h0003_0000, "R8 set ORs");
    wr(A_IEN_C, 32'h0002_0000);
    chk_rd(A_IEN_C, 32'h0001_0000, "R8 clr removes");
    chk_irq(1'b0, "R8 irq after disable");
    wr(A_IEN_C, 32'h0001_0000);
    wr(8'h44, 32'd0);
    chk_rd(8'h44, 32'd0, "R5 write zero clears");

    // R5 set beats same-cycle clear (timer tick)
    wr(A_MODE, 32'd0);
    wr(A_CLEAR, 32'd1);
    wr(8'hA8, 32'd2);
    wr(8'h48, 32'd0);
    wr(A_START, 32'd1);
    tick(1);
    wr(8'h48, 32'd0, 1'b1);
    chk_rd(8'h48, 32'd1, "R5 set wins over clear");
    wr(A_STOP, 32'd1);

    // R6 shortcut clear
    wr(A_MODE, 32'd1);
    wr(A_CLEAR, 32'd1);
    wr(8'hA0, 32'd4);
    wr(A_SHORTS, 32'h0000_0001);
    count(4);
    chk_cnt(32'd0, "R6 short clears");
    count(1);
    chk_cnt(32'd1, "R6 counts on");

    // R7 shortcut stop
    wr(A_MODE, 32'd0);
    wr(A_SHORTS, 32'h0000_0400);
    chk_rd(A_SHORTS, 32'h0000_0400, "R7 shorts readback");
    wr(8'hA8, 32'd3);
    wr(A_CLEAR, 32'd1);
    wr(A_START, 32'd1);
    tick(6);
    chk_cnt(32'd3, "R7 short stops");
    chk_rd(8'h48, 32'd1, "R7 event2 set");

    // R9 capture sees pre-increment value
    wr(A_START, 32'd1);
    wr(8'h10, 32'd1, 1'b1);
    chk_rd(8'hA0, 32'd3, "R9 capture pre-increment");
    chk_cnt(32'd4, "R9 counter advanced");
    wr(A_STOP, 32'd1);

    // R12 unmapped write ignored
    wr(8'hFC, 32'd1);
    chk_rd(8'hFC, 32'd0, "R12 unmapped write");

    repeat (3) @(posedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule